// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a clocked single-port static memory with an 18-bit word split into two 9-bit lanes. Address, write data, the three chip enables and the write controls are all sampled on the rising clock edge. A new access may start on every cycle. The burst address counter is a separate block that feeds the address input.

A run-time mode input picks the read latency. In flow-through mode the word appears in the cycle right after the capturing edge. In pipelined mode it passes through an output register and appears one cycle later. The output drive follows single-cycle deselect: a deselect or write turns the drive off straight after its capturing edge, one stage ahead of where read data would land.

The bidirectional bus is split into read data, write data and a drive-enable output. The output enable and the sleep input act on the drive asynchronously. Sleep also blocks accesses at the clock edge, and the stored contents are kept.

Top module: `sync_burst_sram`

## Requirements
- R1: An access is taken only when `ce1N`=0, `ce2`=1 and `ce3N`=0 at the edge. Otherwise nothing is written and `drvEn` is 0 for the following cycle.
- R2: With `pipeMode`=0 (flow-through), a read captured at an edge drives `drvEn`=1 and `rdData` = word at the captured address during the next cycle.
- R3: With `pipeMode`=1 (pipelined), read data reaches `rdData` one edge later than in R2, so it is driven in the second cycle after capture.
- R4: With `globalWrN`=1 and `byteWrN`=0, each lane whose strobe is 0 is written: `laneStbN[0]` selects bits 8:0 and `laneStbN[1]` selects bits 17:9. Other lanes keep their value.
- R5: `globalWrN`=0 writes both lanes, whatever `byteWrN` and `laneStbN` are.
- R6: A selected cycle with no active lane (`globalWrN`=1 and either `byteWrN`=1 or `laneStbN`=2'b11) writes nothing and is a read.
- R7: A write never drives the bus: `drvEn`=0 in the cycle after a captured write.
- R8: In pipelined mode, a deselect captured right after a read turns `drvEn` off in the next cycle, so the pending read data is not driven.
- R9: `outEnN`=1 forces `drvEn`=0 at once, without waiting for a clock edge.
- R10: `sleep`=1 forces `drvEn`=0 at once. An access presented at an edge while it is high is ignored, and memory contents are kept.
- R11: Reads issued on consecutive cycles return each word in order with no idle cycles, in both modes.
- R12: After reset `drvEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline state |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| adr | input | ADDR_W | Word address |
| wrData | input | 18 | Write data |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrN | input | 1 | Lane-write qualifier, active low |
| laneStbN | input | 2 | Per-lane write strobes, active low |
| pipeMode | input | 1 | 1 = pipelined reads, 0 = flow-through |
| outEnN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdData | output | 18 | Read data |
| drvEn | output | 1 | High when the block drives the data bus |

## Verification
The bench drives inputs just after a clock edge and samples the outputs 1 ns after the next edge. A write therefore lands at that edge, and in flow-through mode the read result and drive state of the captured cycle can be seen at that sample point. In pipelined mode the same read result is expected one edge later. A deselect is expected to clear the drive after its own edge, before the data of the read ahead of it would appear. Output enable and sleep are toggled between edges, and `drvEn` is sampled after a 1 ns settle with no clock edge in between, to show that their effect does not wait for the clock.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic [LANES-1:0] laneWe;   // lane write strobes, valid at the capturing edge
    logic             loadAdr;  // register read address
    logic             loadOut;  // load pipelined output register
    logic             selFlow;  // present unregistered word
  } sramStb_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             globalWrN,
  input  logic             byteWrN,
  input  logic [LANES-1:0] laneStbN,
  input  logic             pipeMode,
  input  logic             outEnN,
  input  logic             sleep,
  output sramStb_t         stb,
  output logic             drvEn
);
  logic             chipSel;
  logic [LANES-1:0] laneReq;
  logic             isWrite;
  logic             capRead;
  logic             s1Read;
  logic             s2Read;
  logic             coreDrive;

  assign chipSel = !ce1N && ce2 && !ce3N && !sleep;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneReq[g] = !globalWrN || (!byteWrN && !laneStbN[g]);
  end

  assign isWrite = |laneReq;
  assign capRead = chipSel && !isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Read <= 1'b0;
      s2Read <= 1'b0;
    end else begin
      s1Read <= capRead;
      s2Read <= s1Read;
    end
  end

  always_comb begin
    stb.laneWe  = chipSel ? laneReq : '0;
    stb.loadAdr = capRead;
    stb.loadOut = s1Read;
    stb.selFlow = !pipeMode;
  end

  // single-cycle deselect: pipelined drive needs the current stage to be a read too
  assign coreDrive = pipeMode ? (s1Read && s2Read) : s1Read;
  assign drvEn     = coreDrive && !outEnN && !sleep;
endmodule

// File: rtl/sram_dpath.sv
module sram_dpath
  import sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sramStb_t          stb,
  input  logic [ADDR_W-1:0] adr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [ADDR_W-1:0] adrQ;
  logic [WORD_W-1:0] flowWord;
  logic [WORD_W-1:0] pipeReg;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (stb.laneWe[g]) laneMem[adr] <= wrData[g*LANE_W +: LANE_W];
    end
    assign flowWord[g*LANE_W +: LANE_W] = laneMem[adrQ];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adrQ    <= '0;
      pipeReg <= '0;
    end else begin
      if (stb.loadAdr) adrQ <= adr;
      if (stb.loadOut) pipeReg <= flowWord;
    end
  end

  assign rdData = stb.selFlow ? flowWord : pipeReg;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic [ADDR_W-1:0] adr,
  input  logic [17:0]       wrData,
  input  logic              globalWrN,
  input  logic              byteWrN,
  input  logic [1:0]        laneStbN,
  input  logic              pipeMode,
  input  logic              outEnN,
  input  logic              sleep,
  output logic [17:0]       rdData,
  output logic              drvEn
);
  sramStb_t stb;

  sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .globalWrN(globalWrN), .byteWrN(byteWrN), .laneStbN(laneStbN),
    .pipeMode(pipeMode), .outEnN(outEnN), .sleep(sleep),
    .stb(stb), .drvEn(drvEn)
  );

  sram_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .adr(adr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic [ADDR_W-1:0] adr,
  input logic [17:0]       wrData,
  input logic              globalWrN,
  input logic              byteWrN,
  input logic [1:0]        laneStbN,
  input logic              pipeMode,
  input logic              outEnN,
  input logic              sleep,
  input logic [17:0]       rdData,
  input logic              drvEn
);
  logic selIn, wrIn, rdIn;
  assign selIn = !ce1N && ce2 && !ce3N && !sleep;
  assign wrIn  = !globalWrN || (!byteWrN && (laneStbN != 2'b11));
  assign rdIn  = selIn && !wrIn;

  // R1
  desel_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selIn |=> !drvEn);
  // R7
  write_nodrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && wrIn) |=> !drvEn);
  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !drvEn);
  // R10
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !drvEn);
  // R2
  flow_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && rdIn) |=> (drvEn || outEnN || sleep || pipeMode));
  // R3
  pipe_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && drvEn) |-> ($past(rdIn, 2) && $past(rdIn, 1)));
  // R8
  scd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && $past(rdIn) && !selIn) |=> !drvEn);
endmodule

bind sync_burst_sram sram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1;
  logic [AW-1:0] adr = '0;
  logic [17:0] wrData = '0;
  logic globalWrN = 1'b1, byteWrN = 1'b1;
  logic [1:0] laneStbN = 2'b11;
  logic pipeMode = 1'b1, outEnN = 1'b0, sleep = 1'b0;
  logic [17:0] rdData;
  logic drvEn;

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sync_burst_sram #(.DEPTH(64)) u0 (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adr(adr), .wrData(wrData), .globalWrN(globalWrN), .byteWrN(byteWrN),
    .laneStbN(laneStbN), .pipeMode(pipeMode), .outEnN(outEnN),
    .sleep(sleep), .rdData(rdData), .drvEn(drvEn)
  );

  // op: 0 deselect, 1 global write, 2 read (flow-through mode)
  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [17:0]   d;
    logic          expDrv;
    logic [17:0]   expData;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd1, 6'd3, 18'h12345, 1'b0, 18'h0},
    '{2'd1, 6'd7, 18'h0ABCD, 1'b0, 18'h0},
    '{2'd2, 6'd3, 18'h0,     1'b1, 18'h12345},
    '{2'd2, 6'd7, 18'h0,     1'b1, 18'h0ABCD},
    '{2'd0, 6'd3, 18'h0,     1'b0, 18'h0},
    '{2'd1, 6'd3, 18'h3FFFF, 1'b0, 18'h0},
    '{2'd2, 6'd3, 18'h0,     1'b1, 18'h3FFFF},
    '{2'd2, 6'd7, 18'h0,     1'b1, 18'h0ABCD}
  };

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic setIn(input logic c1, input logic c2, input logic c3,
                       input logic gw, input logic bw, input logic [1:0] stbN,
                       input logic [AW-1:0] a, input logic [17:0] d);
    ce1N = c1; ce2 = c2; ce3N = c3;
    globalWrN = gw; byteWrN = bw; laneStbN = stbN;
    adr = a; wrData = d;
  endtask

  task automatic idle();
    setIn(1, 0, 1, 1, 1, 2'b11, '0, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a);
    setIn(0, 1, 0, 1, 1, 2'b11, a, '0);
  endtask

  task automatic wrG(input logic [AW-1:0] a, input logic [17:0] d);
    setIn(0, 1, 0, 0, 1, 2'b11, a, d);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    nCmp++;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [17:0] prev;
    idle();
    repeat (3) step();
    // R12: reset state
    chk("R12 drvEn in reset", {17'b0, drvEn}, 18'd0);
    rstN = 1'b1;
    step();
    chk("R12 drvEn after reset", {17'b0, drvEn}, 18'd0);

    // table walk, flow-through: R2, R5, R7, R11
    pipeMode = 1'b0;
    for (int i = 0; i < 8; i++) begin
      case (VECS[i].op)
        2'd1: wrG(VECS[i].a, VECS[i].d);
        2'd2: rd(VECS[i].a);
        default: idle();
      endcase
      step();
      chk($sformatf("R2/R7/R11 vec%0d drive", i), {17'b0, drvEn}, {17'b0, VECS[i].expDrv});
      if (VECS[i].expDrv) chk($sformatf("R2/R11 vec%0d data", i), rdData, VECS[i].expData);
    end

    // R4: lane 0 only, then lane 1 only
    setIn(0, 1, 0, 1, 0, 2'b10, 6'd3, 18'h00000);
    step();
    chk("R7 byte write no drive", {17'b0, drvEn}, 18'd0);
    rd(6'd3); step();
    chk("R4 lane0 write", rdData, 18'h3FE00);
    prev = rdData;
    setIn(0, 1, 0, 1, 0, 2'b01, 6'd3, 18'h2A955);
    step();
    rd(6'd3); step();
    chk("R4 lane1 write", rdData, {9'h154, prev[8:0]});

    // R5: global overrides lane controls
    setIn(0, 1, 0, 0, 0, 2'b10, 6'd3, 18'h0F0F0);
    step();
    rd(6'd3); step();
    chk("R5 global override", rdData, 18'h0F0F0);

    // R6: byte-write qualifier with no lane strobe is a read
    setIn(0, 1, 0, 1, 0, 2'b11, 6'd3, 18'h11111);
    step();
    chk("R6 no-lane drive", {17'b0, drvEn}, 18'd1);
    chk("R6 no-lane data", rdData, 18'h0F0F0);

    // R1: each enable wrong in turn blocks a write
    setIn(1, 1, 0, 0, 1, 2'b11, 6'd7, 18'h00001); step();
    chk("R1 ce1N high no drive", {17'b0, drvEn}, 18'd0);
    setIn(0, 0, 0, 0, 1, 2'b11, 6'd7, 18'h00002); step();
    setIn(0, 1, 1, 0, 1, 2'b11, 6'd7, 18'h00003); step();
    rd(6'd7); step();
    chk("R1 deselected writes ignored", rdData, 18'h0ABCD);
    setIn(0, 1, 1, 1, 1, 2'b11, 6'd7, '0); step();
    chk("R1 ce3N high read no drive", {17'b0, drvEn}, 18'd0);

    // R9: asynchronous output enable
    rd(6'd7); step();
    idle();
    outEnN = 1'b1; #1;
    chk("R9 outEn off async", {17'b0, drvEn}, 18'd0);
    outEnN = 1'b0; #1;
    chk("R9 outEn on async", {17'b0, drvEn}, 18'd1);
    step();

    // R10: sleep async, blocks access, keeps data
    rd(6'd7); step();
    sleep = 1'b1; #1;
    chk("R10 sleep off async", {17'b0, drvEn}, 18'd0);
    wrG(6'd7, 18'h3C3C3); step();
    sleep = 1'b0;
    rd(6'd7); step();
    chk("R10 sleep write ignored", rdData, 18'h0ABCD);
    chk("R10 drive after wake", {17'b0, drvEn}, 18'd1);

    // R3 / R11: pipelined back-to-back reads
    idle(); step();
    pipeMode = 1'b1;
    rd(6'd3); step();
    chk("R3 first pipe cycle no drive", {17'b0, drvEn}, 18'd0);
    rd(6'd7); step();
    chk("R3 pipe drive", {17'b0, drvEn}, 18'd1);
    chk("R3 pipe data late", rdData, 18'h0F0F0);
    rd(6'd3); step();
    chk("R11 pipe back-to-back", rdData, 18'h0ABCD);
    // R8: deselect right after read drops the drive
    idle(); step();
    chk("R8 single-cycle deselect", {17'b0, drvEn}, 18'd0);
    // R7 in pipelined mode: read then write
    rd(6'd7); step();
    rd(6'd7); step();
    chk("R11 pipe read", rdData, 18'h0ABCD);
    wrG(6'd9, 18'h00055); step();
    chk("R7 pipe write no drive", {17'b0, drvEn}, 18'd0);
    idle(); step();

    summary();
  end
endmodule